// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is one PS/2 host port behind a four-register interface: a status word, a control word, a transmit data register and a receive data register. It shifts in the 11-bit frames a device clocks toward the host and holds each byte with parity and framing flags. It sends host bytes by first inhibiting the clock, then pulling data low as a request to send, then shifting the frame out against the device's clock. The open-drain clock and data lines are driven only through output-enable pins. A keyboard and a mouse take one instance each.

Software brings a port up by holding the control reset bit together with clock inhibit for about 100 µs. It then writes receive-clock enable, transmit enable and receive interrupt enable. It polls the transmit-empty flag before each write, and it reads the receive register when the interrupt fires.

Register map (addr): 0 status, 1 control, 2 transmit data, 3 receive data. Status bits: 0 filtered clock line, 1 clock-inhibit output, 2 transmit busy, 3 transmit empty, 4 receive full, 5 receive busy, 6 parity error, 7 framing error. Control bits: 0 hold inhibit after transmit, 1 transmit enable, 2 transmit interrupt enable, 3 receive interrupt enable, 4 receive-clock enable, 5 port reset.

Top module: `ps2_host_port`

## Requirements
- R1: After rst_n, and while control bit 5 is 1, the transmit buffer is empty (status bit 3 = 1), receive full, busy and both error flags are 0. After rst_n, control reads 0.
- R2: A device frame of start 0, eight data bits LSB first, parity and stop, sampled on filtered falling clock edges, sets status bit 4 and returns the byte in the low 8 bits of the receive register.
- R3: A frame whose data and parity bits hold an even number of ones sets status bit 6. A frame with correct odd parity clears it.
- R4: A received stop bit of 0 sets status bit 7. A stop bit of 1 clears it.
- R5: Reading the receive register (rd_en with addr 3) clears status bit 4.
- R6: With control bit 4 at 0 and no transmission, the clock output enable is 1 and no frame is received. Status bit 0 shows the filtered clock line and status bit 1 shows the clock output enable.
- R7: A write to the transmit register is taken only while status bit 3 is 1. Otherwise it is dropped. No transmission starts while control bit 1 is 0.
- R8: A transmission holds the clock low for at least INHIBIT_CYCLES cycles, then releases it with data held low. On device falling edges it shifts out the data LSB first, then odd parity, then stop 1. Status bit 2 is 1 throughout, and status bit 3 returns to 1 at the end.
- R9: If the device does not drive acknowledge 0 on the eleventh falling edge, status bit 7 is set. A good acknowledge clears it.
- R10: With control bit 0 set, the clock output enable stays 1 after a transmission ends, until control bit 0 is cleared.
- R11: irq = (status bit 4 AND control bit 3) OR (status bit 3 AND control bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears receive full at addr 3) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| ps2_clk_i | input | 1 | Sensed clock line |
| ps2_dat_i | input | 1 | Sensed data line |
| ps2_clk_oe | output | 1 | Pull clock line low when 1 |
| ps2_dat_oe | output | 1 | Pull data line low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a host transmission. It needs a device that notices the released clock with data held low, then produces eleven clock pulses, samples the host's bits on each rising edge and answers or withholds the acknowledge. The bench models both lines as wired-AND of the block's enables and the device's drivers. A device task waits for the request-to-send condition and counts the inhibit cycles. It then clocks the frame while recording the status word in mid-frame, and it can leave the acknowledge undriven to reach the error path.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_TX   = 2'd2;
  localparam logic [1:0] ADDR_RX   = 2'd3;

  localparam int C_HOLD_INH = 0;
  localparam int C_TX_EN    = 1;
  localparam int C_TX_IE    = 2;
  localparam int C_RX_IE    = 3;
  localparam int C_RX_CLKEN = 4;
  localparam int C_PORT_RST = 5;

  localparam int FRAME_LAST = 10;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_INHIB = 2'd1,
    TX_RTS   = 2'd2,
    TX_SHIFT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic          s1_q, s2_q, level_q, level_d, fall_q, fall_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    level_d = level_q;
    fall_d  = 1'b0;
    cnt_d   = '0;
    if (s2_q != level_q) begin
      if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        level_d = s2_q;
        fall_d  = ~s2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      level_q <= 1'b1;
      fall_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      s1_q    <= raw_i;
      s2_q    <= s1_q;
      level_q <= level_d;
      fall_q  <= fall_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = level_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/ps2_rx_deframer.sv
module ps2_rx_deframer
  import ps2_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] byte_o,
  output logic       par_err_o,
  output logic       frm_err_o
);
  logic [3:0] cnt_q, cnt_d;
  logic [8:0] sh_q, sh_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (fall_i) begin
      if (cnt_q == 4'd0) begin
        if (!dat_i) cnt_d = 4'd1;
      end else if (cnt_q == 4'(FRAME_LAST)) begin
        cnt_d = '0;
      end else begin
        sh_d  = {dat_i, sh_q[8:1]};
        cnt_d = cnt_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign busy_o    = (cnt_q != 4'd0);
  assign done_o    = fall_i && !clr_i && (cnt_q == 4'(FRAME_LAST));
  assign byte_o    = sh_q[7:0];
  assign par_err_o = ~(^sh_q);
  assign frm_err_o = ~dat_i;

  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !busy_o); // R6
endmodule

// File: rtl/ps2_tx_engine.sv
module ps2_tx_engine
  import ps2_host_pkg::*;
#(
  parameter int INHIBIT_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       ack_err_o,
  output logic       clk_oe_o,
  output logic       dat_oe_o
);
  localparam int IW = $clog2(INHIBIT_CYCLES + 1);

  tx_state_e      state_q, state_d;
  logic [IW-1:0]  inh_q, inh_d;
  logic [3:0]     bit_q, bit_d;
  logic [10:0]    frame_q, frame_d;

  always_comb begin
    state_d = state_q;
    inh_d   = inh_q;
    bit_d   = bit_q;
    frame_d = frame_q;
    unique case (state_q)
      TX_IDLE: if (start_i) begin
        state_d = TX_INHIB;
        inh_d   = '0;
        frame_d = {1'b1, ~(^byte_i), byte_i, 1'b0};
      end
      TX_INHIB: begin
        if (inh_q == IW'(INHIBIT_CYCLES - 1)) state_d = TX_RTS;
        else inh_d = inh_q + 1'b1;
      end
      TX_RTS: begin
        state_d = TX_SHIFT;
        bit_d   = '0;
      end
      TX_SHIFT: if (fall_i) begin
        if (bit_q == 4'(FRAME_LAST)) state_d = TX_IDLE;
        else bit_d = bit_q + 4'd1;
      end
      default: state_d = TX_IDLE;
    endcase
    if (clr_i) state_d = TX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      inh_q   <= '0;
      bit_q   <= '0;
      frame_q <= '0;
    end else begin
      state_q <= state_d;
      inh_q   <= inh_d;
      bit_q   <= bit_d;
      frame_q <= frame_d;
    end
  end

  assign busy_o    = (state_q != TX_IDLE);
  assign clk_oe_o  = (state_q == TX_INHIB) || (state_q == TX_RTS);
  assign dat_oe_o  = (state_q == TX_RTS) || ((state_q == TX_SHIFT) && !frame_q[bit_q]);
  assign done_o    = (state_q == TX_SHIFT) && fall_i && !clr_i && (bit_q == 4'(FRAME_LAST));
  assign ack_err_o = dat_i;
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
  import ps2_host_pkg::*;
#(
  parameter int FILT_CYCLES    = 4,
  parameter int INHIBIT_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe,
  output logic       irq
);
  logic [5:0] ctrl_q, ctrl_d;
  logic [7:0] tx_buf_q, tx_buf_d, rx_data_q, rx_data_d;
  logic       tx_empty_q, tx_empty_d, rx_full_q, rx_full_d;
  logic       perr_q, perr_d, ferr_q, ferr_d, hold_q, hold_d;

  logic       clk_lvl, clk_fall, dat_lvl, dat_fall_unused;
  logic       rx_busy, rx_done, rx_perr, rx_ferr, rx_clr;
  logic [7:0] rx_byte;
  logic       tx_busy, tx_done, tx_ack_err, tx_start, tx_clk_oe;
  logic       port_rst, wr_tx_ok, rd_rx;

  ps2_line_sync #(.FILT_CYCLES(FILT_CYCLES)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(ps2_clk_i), .level_o(clk_lvl), .fall_o(clk_fall));
  ps2_line_sync #(.FILT_CYCLES(FILT_CYCLES)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(ps2_dat_i), .level_o(dat_lvl), .fall_o(dat_fall_unused));

  assign port_rst = ctrl_q[C_PORT_RST];
  assign rx_clr   = port_rst || !ctrl_q[C_RX_CLKEN] || tx_busy;
  assign tx_start = ctrl_q[C_TX_EN] && !tx_empty_q && !tx_busy && !port_rst;
  assign wr_tx_ok = wr_en && (addr == ADDR_TX) && tx_empty_q && !port_rst;
  assign rd_rx    = rd_en && (addr == ADDR_RX);

  ps2_rx_deframer u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(rx_clr), .fall_i(clk_fall), .dat_i(dat_lvl),
    .busy_o(rx_busy), .done_o(rx_done), .byte_o(rx_byte),
    .par_err_o(rx_perr), .frm_err_o(rx_ferr));

  ps2_tx_engine #(.INHIBIT_CYCLES(INHIBIT_CYCLES)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr_i(port_rst), .start_i(tx_start), .byte_i(tx_buf_q),
    .fall_i(clk_fall), .dat_i(dat_lvl), .busy_o(tx_busy), .done_o(tx_done),
    .ack_err_o(tx_ack_err), .clk_oe_o(tx_clk_oe), .dat_oe_o(ps2_dat_oe));

  always_comb begin
    ctrl_d     = ctrl_q;
    tx_buf_d   = tx_buf_q;
    rx_data_d  = rx_data_q;
    tx_empty_d = tx_empty_q;
    rx_full_d  = rx_full_q;
    perr_d     = perr_q;
    ferr_d     = ferr_q;
    hold_d     = hold_q;
    if (wr_en && (addr == ADDR_CTRL)) ctrl_d = wdata[5:0];
    if (wr_tx_ok) begin
      tx_buf_d   = wdata;
      tx_empty_d = 1'b0;
    end
    if (tx_done) begin
      tx_empty_d = 1'b1;
      ferr_d     = tx_ack_err;
      hold_d     = ctrl_q[C_HOLD_INH];
    end
    if (rd_rx) rx_full_d = 1'b0;
    if (rx_done) begin
      rx_data_d = rx_byte;
      rx_full_d = 1'b1;
      perr_d    = rx_perr;
      ferr_d    = rx_ferr;
    end
    if (tx_start || !ctrl_q[C_HOLD_INH]) hold_d = 1'b0;
    if (port_rst) begin
      tx_empty_d = 1'b1;
      rx_full_d  = 1'b0;
      perr_d     = 1'b0;
      ferr_d     = 1'b0;
      hold_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      tx_buf_q   <= '0;
      rx_data_q  <= '0;
      tx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      tx_buf_q   <= tx_buf_d;
      rx_data_q  <= rx_data_d;
      tx_empty_q <= tx_empty_d;
      rx_full_q  <= rx_full_d;
      perr_q     <= perr_d;
      ferr_q     <= ferr_d;
      hold_q     <= hold_d;
    end
  end

  assign ps2_clk_oe = tx_clk_oe || hold_q || (!ctrl_q[C_RX_CLKEN] && !tx_busy);
  assign irq = (rx_full_q && ctrl_q[C_RX_IE]) || (tx_empty_q && ctrl_q[C_TX_IE]);

  always_comb begin
    unique case (addr)
      ADDR_STAT: rdata = {ferr_q, perr_q, rx_busy, rx_full_q, tx_empty_q, tx_busy, ps2_clk_oe, clk_lvl};
      ADDR_CTRL: rdata = {2'b00, ctrl_q};
      ADDR_TX:   rdata = tx_buf_q;
      default:   rdata = rx_data_q;
    endcase
  end

  AST_RESET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |=> tx_empty_q && !rx_full_q); // R1
  AST_RXFULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && !rx_done |=> !rx_full_q); // R5
  AST_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == ADDR_TX) && !tx_empty_q |=> $stable(tx_buf_q)); // R7
  AST_CLK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) && tx_busy |-> ps2_dat_oe); // R8
endmodule

// File: tb/ps2_host_port_test.sv
module ps2_host_port_test;
  localparam int INH  = 40;
  localparam int HALF = 12;

  logic       clk, rst_n, wr_en, rd_en, dev_clk, dev_dat;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       ps2_clk_oe, ps2_dat_oe, irq, clk_line, dat_line;
  int         tests, fails;

  assign clk_line = dev_clk & ~ps2_clk_oe;
  assign dat_line = dev_dat & ~ps2_dat_oe;

  ps2_host_port #(.FILT_CYCLES(4), .INHIBIT_CYCLES(INH)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe), .irq(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // fields: byte[11:4], corrupt parity[3], stop bit[2], exp parity err[1], exp framing err[0]
  localparam logic [11:0] VEC [6] = '{12'h004, 12'hFF4, 12'hA5E, 12'h3C1, 12'h81B, 12'h7E4};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic dev_send(input logic [7:0] b, input logic badpar, input logic stop);
    logic [10:0] fr;
    fr = {stop, (~(^b)) ^ badpar, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      dev_dat = fr[i];
      repeat (HALF) @(negedge clk); dev_clk = 1'b0;
      repeat (HALF) @(negedge clk); dev_clk = 1'b1;
    end
    dev_dat = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic dev_recv(input logic give_ack, output logic [10:0] got,
                          output int inh, output logic [7:0] mid_stat);
    inh = 0;
    do begin
      @(negedge clk);
      if (ps2_clk_oe) inh++;
    end while (!(!ps2_clk_oe && ps2_dat_oe));
    for (int i = 0; i < 11; i++) begin
      if (i == 10 && give_ack) dev_dat = 1'b0;
      repeat (HALF) @(negedge clk); dev_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      got[i] = dat_line;
      if (i == 4) peek(2'd0, mid_stat);
      dev_clk = 1'b1;
    end
    dev_dat = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0]  s, d;
    logic [10:0] got;
    int          inh;
    tests = 0; fails = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0;
    dev_clk = 1'b1; dev_dat = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    peek(2'd0, s); check("R1 status after reset", s, 8'h0A);
    peek(2'd1, s); check("R1 control after reset", s, 8'h00);
    check("R11 irq with no enables", irq, 1'b0);

    wr(2'd1, 8'h18);
    repeat (10) @(negedge clk);
    peek(2'd0, s); check("R6 line mirror released", s[1:0], 2'b01);

    foreach (VEC[k]) begin
      dev_send(VEC[k][11:4], VEC[k][3], VEC[k][2]);
      repeat (4) @(negedge clk);
      peek(2'd0, s);
      check("R2 rx full", s[4], 1'b1);
      check("R3 parity flag", s[6], VEC[k][1]);
      check("R4 framing flag", s[7], VEC[k][0]);
      check("R11 irq on rx full", irq, 1'b1);
      rd(2'd3, d); check("R2 rx byte", d, VEC[k][11:4]);
      peek(2'd0, s); check("R5 rx full cleared by read", s[4], 1'b0);
      check("R11 irq drops after read", irq, 1'b0);
    end

    wr(2'd1, 8'h08);
    repeat (10) @(negedge clk);
    check("R6 clock inhibited when paused", ps2_clk_oe, 1'b1);
    peek(2'd0, s); check("R6 status inhibit and line", s[1:0], 2'b10);
    dev_send(8'h55, 1'b0, 1'b1);
    peek(2'd0, s); check("R6 no frame while paused", s[5:4], 2'b00);

    wr(2'd1, 8'h14);
    @(negedge clk); check("R11 irq on tx empty", irq, 1'b1);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'hA5);
    repeat (100) @(negedge clk);
    peek(2'd0, s); check("R7 held while tx disabled", {s[3:2], ps2_clk_oe}, 3'b000);
    wr(2'd2, 8'h3C);
    peek(2'd2, d); check("R7 write dropped when full", d, 8'hA5);

    wr(2'd1, 8'h12);
    dev_recv(1'b1, got, inh, s);
    check("R8 inhibit length", inh >= INH, 1'b1);
    check("R8 data bits", got[7:0], 8'hA5);
    check("R8 parity and stop", got[9:8], {1'b1, ~(^8'hA5)});
    check("R8 busy mid frame", s[3:2], 2'b01);
    repeat (4) @(negedge clk);
    peek(2'd0, s); check("R8 done status", {s[7], s[3:2]}, 3'b010);
    check("R10 released without hold", ps2_clk_oe, 1'b0);

    wr(2'd1, 8'h13);
    wr(2'd2, 8'h5A);
    dev_recv(1'b0, got, inh, s);
    check("R8 second byte", got[7:0], 8'h5A);
    repeat (4) @(negedge clk);
    peek(2'd0, s); check("R9 missing ack flag", s[7], 1'b1);
    check("R10 hold inhibit after tx", {ps2_clk_oe, s[1]}, 2'b11);
    wr(2'd1, 8'h12);
    @(negedge clk); check("R10 hold cleared", ps2_clk_oe, 1'b0);

    repeat (10) @(negedge clk);
    dev_send(8'h99, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    peek(2'd0, s); check("R2 full before port reset", {s[6], s[4]}, 2'b11);
    wr(2'd1, 8'h21);
    repeat (10) @(negedge clk);
    peek(2'd0, s); check("R1 status under port reset", s, 8'h0A);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule